// File: doc/BRIEF.md
# Light-Sensor Integration Sequencer

This block runs the conversion cycle of an integrating light-to-count converter. The analog front end delivers one strobe per charge-balance pulse. The oscillator delivers a clock-enable tick. The sequencer counts pulses over an integration window and then publishes two values together: a 16-bit sensor result and a 16-bit timer count, which is the number of ticks in that window. A one-cycle valid pulse marks each update, so that downstream threshold or interrupt logic can evaluate every result.

The window can be timed internally, by a power-of-two number of ticks selected by a width code. It can also be timed externally, by one-cycle sync commands from the host. The diode-select mode chooses one of four operations:

- convert diode 1 only,
- convert diode 2 only,
- convert diode 1 and then diode 2, and output their signed difference,
- do nothing.

A `diodeSel` output tells the front end which diode to route. The range code selects the tick rate: the low ranges count only every second oscillator tick.

Top module: `lux_integ_seq`

## Requirements
- R1: While `enable` is 0, the block stays idle. `sensorData`, `timerCount`, `resultValid` and `timerOverflow` read 0 on the cycle after `enable` is sampled low.
- R2: With `extTiming` = 0, width code 0/1/2/3 gives a window of 65536/4096/256/16 counted ticks. The published `sensorData` is the number of cycles inside the window that had `pulse` high, including the final cycle. `resultValid` is high for exactly the one cycle after the last tick. The next window starts with no gap, so with a tick every cycle, results arrive every window-length cycles.
- R3: With range code 0 or 1, only every second `oscTick` is counted, the first counted one being the second tick after a window starts. With range code 2 or 3, every `oscTick` is counted. `timerCount` reports the counted ticks.
- R4: Mode 0 converts diode 1 with `diodeSel` = 0. Mode 1 converts diode 2 with `diodeSel` = 1.
- R5: Mode 2 integrates a diode-1 window (`diodeSel` = 0) and then a diode-2 window (`diodeSel` = 1). It publishes D1 − D2, clamped to the range −16384..16383 and sign-extended to 16 bits. `timerCount` gives the ticks of the diode-2 window.
- R6: Mode 3 performs no conversion. Any running window is abandoned, `resultValid` stays low, and `sensorData` and `timerCount` hold their values.
- R7: With `extTiming` = 1, the width code is ignored. Nothing starts until the first `syncCmd`. Each later `syncCmd` ends the window, counting its own cycle, publishes the result, and starts the next window on the following cycle.
- R8: In mode 2 with external timing, three syncs make one result: the first starts diode 1, the second switches to diode 2 without publishing, and the third publishes and restarts diode 1.
- R9: The timer count saturates at 0xFFFF. `timerOverflow` is set when a counted tick arrives while the timer is already at 0xFFFF. It stays set until `enable` goes low.
- R10: The pulse counter saturates at 0xFFFF instead of wrapping.
- R11: While `powerDown` is 1, the window is abandoned, no result is published and the outputs hold. After release, a complete new window runs: in internal timing with a tick every cycle and width code 3, the next `resultValid` is seen 17 cycles after `powerDown` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 0 holds the sequencer cleared |
| powerDown | input | 1 | 1 halts conversion |
| extTiming | input | 1 | 0 internal window, 1 sync-timed window |
| mode | input | 2 | 0 diode 1, 1 diode 2, 2 difference, 3 none |
| width | input | 2 | Internal window length code |
| rangeSel | input | 2 | Range code; 0 and 1 halve the tick rate |
| oscTick | input | 1 | Oscillator clock-enable tick |
| pulse | input | 1 | Charge-balance pulse strobe from the front end |
| syncCmd | input | 1 | One-cycle external sync command |
| sensorData | output | 16 | Latest published result |
| timerCount | output | 16 | Ticks counted in the latest window |
| resultValid | output | 1 | One-cycle pulse on each publish |
| timerOverflow | output | 1 | Sticky timer saturation flag |
| diodeSel | output | 1 | 0 routes diode 1, 1 routes diode 2 |

## Verification
The bench builds the block with its default `CNT_W` of 16. This keeps the real 65536-tick window, which is long enough to drive both the pulse counter and the timer into saturation and set the overflow flag within one run. The short width codes keep every mode and range combination cheap. An externally timed diode-1 window of 20000 cycles pushes the difference past the 15-bit signed limit, which exercises the clamp without needing two full-length internal windows.

// File: rtl/lux_seq_pkg.sv
package lux_seq_pkg;
  localparam logic [1:0] MODE_D1   = 2'd0;
  localparam logic [1:0] MODE_D2   = 2'd1;
  localparam logic [1:0] MODE_DIFF = 2'd2;
  localparam logic [1:0] MODE_NONE = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_D1, PH_D2} phase_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic clearAll;   // hold everything cleared
    logic clearCnt;   // restart the window counters
    logic countEn;    // a window is running
    logic tickEn;     // counted tick this cycle
    logic latchD1;    // keep the diode-1 count
    logic pubSingle;  // publish a single-diode result
    logic pubDiff;    // publish the difference result
  } seq_strobe_t;
endpackage

// File: rtl/lux_seq_ctrl.sv
module lux_seq_ctrl
  import lux_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        powerDown,
  input  logic        extTiming,
  input  logic [1:0]  mode,
  input  logic [1:0]  width,
  input  logic [1:0]  rangeSel,
  input  logic        oscTick,
  input  logic        syncCmd,
  output seq_strobe_t st,
  output logic        diodeSel
);
  localparam int WIN_W = CNT_W + 1;
  localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

  phase_e phase, phaseNext, firstPh;
  logic [WIN_W-1:0] winCnt, winLim;
  logic halfTgl, slowRange, effTick, run, busy, intEnd, extEnd, phaseEnd;

  always_comb begin
    case (width)
      2'd0:    winLim = WIN_ONE << CNT_W;
      2'd1:    winLim = WIN_ONE << (CNT_W - 4);
      2'd2:    winLim = WIN_ONE << (CNT_W - 8);
      default: winLim = WIN_ONE << (CNT_W - 12);
    endcase
  end

  assign slowRange = (rangeSel < 2'd2);
  assign effTick   = oscTick & (~slowRange | halfTgl);
  assign run       = enable & ~powerDown & (mode != MODE_NONE);
  assign busy      = (phase != PH_IDLE);
  assign intEnd    = busy & ~extTiming & effTick & (winCnt >= winLim - WIN_ONE);
  assign extEnd    = busy & extTiming & syncCmd;
  assign phaseEnd  = intEnd | extEnd;
  assign firstPh   = (mode == MODE_D2) ? PH_D2 : PH_D1;
  assign diodeSel  = (phase == PH_D2);

  always_comb begin
    st          = '0;
    st.clearAll = ~enable;
    st.countEn  = busy & run;
    st.tickEn   = effTick;
    phaseNext   = phase;
    if (!run) begin
      phaseNext = PH_IDLE;
    end else if (!busy) begin
      if (!extTiming || syncCmd) begin
        phaseNext   = firstPh;
        st.clearCnt = 1'b1;
      end
    end else if (phaseEnd) begin
      st.clearCnt = 1'b1;
      if (phase == PH_D1 && mode == MODE_DIFF) begin
        st.latchD1 = 1'b1;
        phaseNext  = PH_D2;
      end else if (phase == PH_D2 && mode == MODE_DIFF) begin
        st.pubDiff = 1'b1;
        phaseNext  = PH_D1;
      end else begin
        st.pubSingle = 1'b1;
        phaseNext    = firstPh;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      winCnt  <= '0;
      halfTgl <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (!enable || st.clearCnt) begin
        winCnt  <= '0;
        halfTgl <= 1'b0;
      end else begin
        if (oscTick) halfTgl <= ~halfTgl;
        if (busy && effTick && !extTiming) winCnt <= winCnt + WIN_ONE;
      end
    end
  end

  // R11
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (phase == PH_IDLE));
endmodule

// File: rtl/lux_seq_dpath.sv
module lux_seq_dpath
  import lux_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      st,
  input  logic             pulse,
  output logic [CNT_W-1:0] sensorData,
  output logic [CNT_W-1:0] timerCount,
  output logic             resultValid,
  output logic             timerOverflow
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic signed [CNT_W:0] DIFF_HI = (CNT_W+1)'((1 << (CNT_W - 2)) - 1);
  localparam logic signed [CNT_W:0] DIFF_LO = -DIFF_HI - (CNT_W+1)'(1);

  logic [CNT_W-1:0] pulseCnt, tickCnt, d1Hold, pulseNext, tickNext, diffOut;
  logic signed [CNT_W:0] diffRaw, diffClamp;
  logic tickAtLimit;

  assign pulseNext = (st.countEn && pulse && pulseCnt != MAXV) ? pulseCnt + ONE : pulseCnt;
  assign tickNext  = (st.countEn && st.tickEn && tickCnt != MAXV) ? tickCnt + ONE : tickCnt;
  assign tickAtLimit = st.countEn & st.tickEn & (tickCnt == MAXV);

  always_comb begin
    diffRaw = $signed({1'b0, d1Hold}) - $signed({1'b0, pulseNext});
    if (diffRaw > DIFF_HI)      diffClamp = DIFF_HI;
    else if (diffRaw < DIFF_LO) diffClamp = DIFF_LO;
    else                        diffClamp = diffRaw;
    diffOut = diffClamp[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0; tickCnt <= '0; d1Hold <= '0;
      sensorData <= '0; timerCount <= '0;
      resultValid <= 1'b0; timerOverflow <= 1'b0;
    end else if (st.clearAll) begin
      pulseCnt <= '0; tickCnt <= '0; d1Hold <= '0;
      sensorData <= '0; timerCount <= '0;
      resultValid <= 1'b0; timerOverflow <= 1'b0;
    end else begin
      resultValid <= st.pubSingle | st.pubDiff;
      if (st.clearCnt) begin
        pulseCnt <= '0;
        tickCnt  <= '0;
      end else if (st.countEn) begin
        pulseCnt <= pulseNext;
        tickCnt  <= tickNext;
      end
      if (st.latchD1)   d1Hold <= pulseNext;
      if (st.pubSingle) sensorData <= pulseNext;
      if (st.pubDiff)   sensorData <= diffOut;
      if (st.pubSingle || st.pubDiff) timerCount <= tickNext;
      if (tickAtLimit) timerOverflow <= 1'b1;
    end
  end

  // R1
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.clearAll |=> (sensorData == '0 && timerCount == '0 && !resultValid && !timerOverflow));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timerOverflow) && !$past(st.clearAll)) |-> timerOverflow);
  // R9
  tick_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tickCnt) == MAXV && !$past(st.clearCnt) && !$past(st.clearAll)) |-> (tickCnt == MAXV));
  // R5
  diff_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.pubDiff |=> ($signed({sensorData[CNT_W-1], sensorData}) <= DIFF_HI &&
                    $signed({sensorData[CNT_W-1], sensorData}) >= DIFF_LO));
endmodule

// File: rtl/lux_integ_seq.sv
module lux_integ_seq
  import lux_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             powerDown,
  input  logic             extTiming,
  input  logic [1:0]       mode,
  input  logic [1:0]       width,
  input  logic [1:0]       rangeSel,
  input  logic             oscTick,
  input  logic             pulse,
  input  logic             syncCmd,
  output logic [CNT_W-1:0] sensorData,
  output logic [CNT_W-1:0] timerCount,
  output logic             resultValid,
  output logic             timerOverflow,
  output logic             diodeSel
);
  seq_strobe_t st;

  lux_seq_ctrl #(.CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .powerDown(powerDown),
    .extTiming(extTiming), .mode(mode), .width(width), .rangeSel(rangeSel),
    .oscTick(oscTick), .syncCmd(syncCmd), .st(st), .diodeSel(diodeSel)
  );

  lux_seq_dpath #(.CNT_W(CNT_W)) dpath (
    .clk(clk), .rstN(rstN), .st(st), .pulse(pulse),
    .sensorData(sensorData), .timerCount(timerCount),
    .resultValid(resultValid), .timerOverflow(timerOverflow)
  );
endmodule

// File: tb/lux_integ_seq_test.sv
`timescale 1ns/1ps
module lux_integ_seq_test;
  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, powerDown = 1'b0, extTiming = 1'b0;
  logic [1:0] mode = '0, width = '0, rangeSel = '0;
  logic oscTick = 1'b1, syncCmd = 1'b0, d1On = 1'b0, d2On = 1'b0;
  logic pulse, resultValid, timerOverflow, diodeSel;
  logic [15:0] sensorData, timerCount;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign pulse = diodeSel ? d2On : d1On;

  lux_integ_seq uut (
    .clk(clk), .rstN(rstN), .enable(enable), .powerDown(powerDown),
    .extTiming(extTiming), .mode(mode), .width(width), .rangeSel(rangeSel),
    .oscTick(oscTick), .pulse(pulse), .syncCmd(syncCmd),
    .sensorData(sensorData), .timerCount(timerCount), .resultValid(resultValid),
    .timerOverflow(timerOverflow), .diodeSel(diodeSel)
  );

  typedef struct packed {
    logic [1:0] vMode; logic [1:0] vWidth; logic [1:0] vRange;
    logic vD1; logic vD2; logic [15:0] expData; logic [15:0] expTimer;
  } vec_t;
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd3, 2'd2, 1'b1, 1'b0, 16'd16,   16'd16},
    '{2'd0, 2'd3, 2'd0, 1'b1, 1'b0, 16'd32,   16'd16},
    '{2'd1, 2'd3, 2'd2, 1'b1, 1'b0, 16'd0,    16'd16},
    '{2'd1, 2'd2, 2'd3, 1'b0, 1'b1, 16'd256,  16'd256},
    '{2'd2, 2'd3, 2'd2, 1'b1, 1'b0, 16'd16,   16'd16},
    '{2'd2, 2'd3, 2'd2, 1'b0, 1'b1, 16'hFFF0, 16'd16},
    '{2'd0, 2'd1, 2'd2, 1'b1, 1'b0, 16'd4096, 16'd4096},
    '{2'd2, 2'd2, 2'd1, 1'b1, 1'b1, 16'd0,    16'd256}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [1:0] w, input logic [1:0] r,
                     input logic a, input logic b, input logic ext);
    @(negedge clk);
    enable = 1'b0; powerDown = 1'b0; syncCmd = 1'b0;
    mode = m; width = w; rangeSel = r; d1On = a; d2On = b; extTiming = ext;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic waitValid(input int limit, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!resultValid && cyc < limit);
    if (!resultValid) cyc = -1;
  endtask

  task automatic waitCount(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (resultValid) seen++;
    end
  endtask

  task automatic sync(output logic vld);
    syncCmd = 1'b1;
    @(negedge clk);
    syncCmd = 1'b0;
    vld = resultValid;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, seen;
    logic vld;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset and disabled state
    check("R1 reset outputs", {sensorData, timerCount}, 32'h0);
    check("R1 reset flags", {resultValid, timerOverflow}, 32'h0);

    // Vector table: R2, R3, R4, R5
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = (VECS[v].vMode == 2'd2) ? "R5" : (VECS[v].vRange < 2'd2) ? "R3" :
            (VECS[v].vMode == 2'd1) ? "R4" : "R2";
      cfg(VECS[v].vMode, VECS[v].vWidth, VECS[v].vRange, VECS[v].vD1, VECS[v].vD2, 1'b0);
      waitValid(70000, cyc);
      check({tag, " valid seen"}, (cyc > 0), 32'h1);
      check({tag, " data"}, sensorData, VECS[v].expData);
      check({tag, " timer"}, timerCount, VECS[v].expTimer);
    end

    // R2: one-cycle valid, back-to-back windows
    cfg(2'd0, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0);
    waitValid(100, cyc);
    @(negedge clk);
    check("R2 valid one cycle", resultValid, 32'h0);
    waitValid(100, cyc);
    check("R2 window period", cyc, 32'd15);

    // R4: diode select
    check("R4 diodeSel mode0", diodeSel, 32'h0);
    cfg(2'd1, 2'd3, 2'd2, 1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check("R4 diodeSel mode1", diodeSel, 32'h1);

    // R11: power-down abandons the window
    cfg(2'd0, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0);
    waitValid(100, cyc);
    repeat (5) @(negedge clk);
    powerDown = 1'b1;
    waitCount(40, seen);
    check("R11 no result in power-down", seen, 32'h0);
    check("R11 data held", sensorData, 32'd16);
    powerDown = 1'b0;
    waitValid(100, cyc);
    check("R11 fresh window latency", cyc, 32'd17);

    // R6: mode 3 does nothing
    cfg(2'd0, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0);
    waitValid(100, cyc);
    repeat (3) @(negedge clk);
    mode = 2'd3;
    waitCount(50, seen);
    check("R6 no result in mode 3", seen, 32'h0);
    check("R6 outputs held", {sensorData, timerCount}, {16'd16, 16'd16});

    // R7: external timing, single diode
    cfg(2'd0, 2'd3, 2'd2, 1'b1, 1'b0, 1'b1);
    waitCount(30, seen);
    check("R7 idle before first sync", seen, 32'h0);
    sync(vld);
    check("R7 first sync publishes nothing", vld, 32'h0);
    waitCount(99, seen);
    check("R7 width ignored", seen, 32'h0);
    sync(vld);
    check("R7 second sync publishes", vld, 32'h1);
    check("R7 data", sensorData, 32'd100);
    check("R7 timer", timerCount, 32'd100);
    waitCount(49, seen);
    sync(vld);
    check("R7 restarted window", {vld, sensorData}, {1'b1, 16'd50});

    // R8: external subtract, three syncs, clamp of R5
    cfg(2'd2, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1);
    sync(vld);
    waitCount(19999, seen);
    sync(vld);
    check("R8 second sync publishes nothing", {seen[0], vld}, 32'h0);
    check("R8 diode 2 selected", diodeSel, 32'h1);
    waitCount(9, seen);
    sync(vld);
    check("R8 third sync publishes", vld, 32'h1);
    check("R5 clamped difference", sensorData, 32'h3FFF);
    check("R8 timer of diode 2", timerCount, 32'd10);
    check("R8 back on diode 1", diodeSel, 32'h0);

    // R9, R10: saturation and sticky overflow
    cfg(2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0);
    check("R9 overflow clear at start", timerOverflow, 32'h0);
    waitValid(70000, cyc);
    check("R10 data saturates", sensorData, 32'hFFFF);
    check("R9 timer saturates", timerCount, 32'hFFFF);
    check("R9 overflow set", timerOverflow, 32'h1);
    repeat (20) @(negedge clk);
    check("R9 overflow sticky", timerOverflow, 32'h1);
    enable = 1'b0;
    @(negedge clk);
    check("R1 disable clears", {timerOverflow, sensorData, timerCount}, 33'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule